// File: doc/BRIEF.md
# Partial Cell Histogram Row Aggregator

This block turns a stream of row-segment histograms into complete cell histograms. Each input word carries the orientation bins of one cell's eight-pixel stretch of a single pixel row. Words arrive in raster order: every cell column of one pixel row, then the next pixel row. The block keeps one running sum per cell column in a line store. It adds each new word to the entry for its column. When the last pixel row of a cell row has been added, it emits the finished cell histogram together with the cell's column and row indices.

The store holds one entry for each cell across the image, which is 80 entries for a 640-pixel line. The block accepts a word on any clock and never asks the source to wait. A start-of-frame pulse puts the position counters back at the top-left cell. Without that pulse, the counters wrap by themselves at the right edge and at the bottom of the frame.

Position tracking is a small state machine with three named states. S_FIRST means the current pixel row is the first of a cell row, so incoming words overwrite the stored entry. S_ACCUM covers the middle pixel rows, where words are added to the stored entry. S_LAST is the final pixel row: words complete the sum and the cell is emitted.

The transitions are taken at row_end, which is an accepted word in the last cell column:
- first_to_accum moves from S_FIRST to S_ACCUM.
- first_to_last moves from S_FIRST to S_LAST, used only when a cell is two pixels tall.
- accum_hold stays in S_ACCUM.
- accum_to_last moves to S_LAST when the next pixel row is the final one.
- last_to_first moves back to S_FIRST and advances the cell row.
- frame_restart forces S_FIRST from any state when the start-of-frame input is high.

Top module: `hog_row_aggregator`

## Requirements
- R1: While reset is asserted and on the first clock after it, cell_valid is low. After reset, the first accepted word belongs to cell column 0, pixel row 0 of cell row 0.
- R2: A word is accepted on every clock with part_valid high, including back-to-back clocks. A clock with part_valid low changes no sum and no position, whatever part_bins holds.
- R3: Each output bin equals the exact sum of the eight matching input bins. This holds even when every input bin is at its full-scale value 2^PART_W-1; the output bin is PART_W+log2(CELL_PX) bits wide, so it holds 64 full-scale pixel magnitudes.
- R4: The word for the first pixel row of a cell row replaces the stored entry. Sums left over from the previous cell row or the previous frame never leak into a new cell.
- R5: cell_valid is high for exactly one clock, on the clock after the word for the last pixel row of a cell is accepted. It is low on every other clock.
- R6: cell_col and cell_row give the emitted cell's position. The column runs 0 to IMG_W/CELL_PX-1 and then wraps to 0 on the next pixel row. The row runs 0 to IMG_H/CELL_PX-1 and then wraps to 0 without a start-of-frame pulse.
- R7: A high sof makes the word in that same clock, if any, count as column 0, pixel row 0 of cell row 0. With part_valid low, sof only resets the position.
- R8: Bin b sits at bits [b*PART_W +: PART_W] of part_bins and at bits [b*SUM_W +: SUM_W] of cell_bins. Each bin is summed independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame, restarts position tracking |
| part_valid | input | 1 | part_bins carries a row-segment histogram |
| part_bins | input | NBINS*PART_W | Row-segment histogram, bin b at [b*PART_W +: PART_W] |
| cell_valid | output | 1 | One-clock pulse for a finished cell |
| cell_col | output | COL_W | Column index of the finished cell |
| cell_row | output | ROW_W | Row index of the finished cell |
| cell_bins | output | NBINS*SUM_W | Finished cell histogram, bin b at [b*SUM_W +: SUM_W] |

## Verification
A wrong column count or a wrong pixel-row count shows at the ports as a shifted cell_col or a cell_valid pulse on the wrong pixel row. Both appear within the first cell row, which is 640 accepted words. An overwrite that never happens, or a missed accumulation, shows as output sums that differ from the sum of the eight inputs, starting with the second cell row after the fault. A fault in the row wrap shows up only at the first cell row of the next frame when no start-of-frame pulse arrives, so the stimulus runs one whole frame and then continues into the next one without the pulse.

// File: rtl/hog_agg_pkg.sv
package hog_agg_pkg;

    // Pixel-row phase within one cell row
    typedef enum logic [1:0] {
        S_FIRST = 2'd0,  // first pixel row: overwrite the stored entry
        S_ACCUM = 2'd1,  // middle pixel rows: add to the stored entry
        S_LAST  = 2'd2   // final pixel row: finish the sum and emit
    } agg_state_e;

    // Per-word command from the position tracker to the datapath
    typedef struct packed {
        logic take;       // a word is accepted this clock
        logic overwrite;  // replace the entry instead of adding to it
        logic emit;       // this word completes a cell
    } agg_cmd_t;

endpackage

// File: rtl/agg_pos_ctrl.sv
module agg_pos_ctrl
    import hog_agg_pkg::*;
#(
    parameter int COLS    = 80,
    parameter int ROWS    = 60,
    parameter int CELL_PX = 8,
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SUB_W  = (CELL_PX > 1) ? $clog2(CELL_PX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             part_valid,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row,
    output agg_cmd_t         cmd
);

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [SUB_W-1:0] SUB_PEN  = SUB_W'(CELL_PX - 2);

    agg_state_e       state_q, state_d, state_e;
    logic [COL_W-1:0] col_q, col_d, col_e;
    logic [ROW_W-1:0] row_q, row_d, row_e;
    logic [SUB_W-1:0] sub_q, sub_d, sub_e;
    logic             row_end;

    // frame_restart: a start-of-frame pulse overrides the stored position
    always_comb begin
        if (sof) begin
            state_e = S_FIRST;
            col_e   = '0;
            row_e   = '0;
            sub_e   = '0;
        end else begin
            state_e = state_q;
            col_e   = col_q;
            row_e   = row_q;
            sub_e   = sub_q;
        end
        row_end = part_valid && (col_e == COL_LAST);
    end

    // Next position and next state
    always_comb begin
        state_d = state_e;
        col_d   = col_e;
        row_d   = row_e;
        sub_d   = sub_e;
        if (part_valid) begin
            col_d = row_end ? '0 : col_e + 1'b1;
        end
        if (row_end) begin
            unique case (state_e)
                S_FIRST: begin
                    sub_d   = sub_e + 1'b1;
                    // first_to_last only when a cell is two rows tall
                    state_d = (sub_e == SUB_PEN) ? S_LAST : S_ACCUM;
                end
                S_ACCUM: begin
                    sub_d   = sub_e + 1'b1;
                    // accum_to_last or accum_hold
                    state_d = (sub_e == SUB_PEN) ? S_LAST : S_ACCUM;
                end
                S_LAST: begin
                    // last_to_first: cell row finished
                    sub_d   = '0;
                    state_d = S_FIRST;
                    row_d   = (row_e == ROW_LAST) ? '0 : row_e + 1'b1;
                end
                default: begin
                    sub_d   = '0;
                    state_d = S_FIRST;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FIRST;
            col_q   <= '0;
            row_q   <= '0;
            sub_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
            sub_q   <= sub_d;
        end
    end

    // Outputs decoded from the effective state
    always_comb begin
        cur_col       = col_e;
        cur_row       = row_e;
        cmd.take      = part_valid;
        cmd.overwrite = 1'b0;
        cmd.emit      = 1'b0;
        unique case (state_e)
            S_FIRST: cmd.overwrite = 1'b1;
            S_ACCUM: cmd.overwrite = 1'b0;
            S_LAST:  cmd.emit      = part_valid;
            default: cmd.overwrite = 1'b1;
        endcase
    end

endmodule

// File: rtl/agg_line_store.sv
module agg_line_store #(
    parameter int DEPTH  = 80,
    parameter int DATA_W = 162,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    // One running sum per cell column; read and write share the address
    logic [DATA_W-1:0] entry_q [DEPTH];

    assign rd_data = entry_q[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            entry_q[addr] <= wr_data;
        end
    end

endmodule

// File: rtl/agg_bin_adder.sv
module agg_bin_adder #(
    parameter int NBINS  = 9,
    parameter int PART_W = 15,
    parameter int SUM_W  = 18
) (
    input  logic                   overwrite,
    input  logic [NBINS*PART_W-1:0] part_bins,
    input  logic [NBINS*SUM_W-1:0]  stored,
    output logic [NBINS*SUM_W-1:0]  result
);

    // One adder per bin; the first pixel row discards the stored sum
    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        logic [SUM_W-1:0] ext_part;
        logic [SUM_W-1:0] base;
        assign ext_part = SUM_W'(part_bins[b*PART_W +: PART_W]);
        assign base     = overwrite ? '0 : stored[b*SUM_W +: SUM_W];
        assign result[b*SUM_W +: SUM_W] = base + ext_part;
    end

endmodule

// File: rtl/hog_row_aggregator.sv
module hog_row_aggregator
    import hog_agg_pkg::*;
#(
    parameter int IMG_W   = 640,
    parameter int IMG_H   = 480,
    parameter int CELL_PX = 8,
    parameter int NBINS   = 9,
    parameter int MAG_W   = 12,
    localparam int COLS   = IMG_W / CELL_PX,
    localparam int ROWS   = IMG_H / CELL_PX,
    localparam int LOG_C  = (CELL_PX > 1) ? $clog2(CELL_PX) : 1,
    localparam int PART_W = MAG_W + LOG_C,
    localparam int SUM_W  = PART_W + LOG_C,
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sof,
    input  logic                     part_valid,
    input  logic [NBINS*PART_W-1:0]  part_bins,
    output logic                     cell_valid,
    output logic [COL_W-1:0]         cell_col,
    output logic [ROW_W-1:0]         cell_row,
    output logic [NBINS*SUM_W-1:0]   cell_bins
);

    logic [COL_W-1:0]       cur_col;
    logic [ROW_W-1:0]       cur_row;
    agg_cmd_t               cmd;
    logic [NBINS*SUM_W-1:0] stored;
    logic [NBINS*SUM_W-1:0] updated;

    agg_pos_ctrl #(
        .COLS    (COLS),
        .ROWS    (ROWS),
        .CELL_PX (CELL_PX)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof),
        .part_valid (part_valid),
        .cur_col    (cur_col),
        .cur_row    (cur_row),
        .cmd        (cmd)
    );

    agg_line_store #(
        .DEPTH  (COLS),
        .DATA_W (NBINS*SUM_W)
    ) i_store (
        .clk     (clk),
        .addr    (cur_col),
        .wr_en   (cmd.take),
        .wr_data (updated),
        .rd_data (stored)
    );

    agg_bin_adder #(
        .NBINS  (NBINS),
        .PART_W (PART_W),
        .SUM_W  (SUM_W)
    ) i_add (
        .overwrite (cmd.overwrite),
        .part_bins (part_bins),
        .stored    (stored),
        .result    (updated)
    );

    // Registered output stage: a finished cell appears one clock later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_valid <= 1'b0;
        end else begin
            cell_valid <= cmd.emit;
        end
    end

    always_ff @(posedge clk) begin
        if (cmd.emit) begin
            cell_col  <= cur_col;
            cell_row  <= cur_row;
            cell_bins <= updated;
        end
    end

endmodule

// File: rtl/hog_agg_checker.sv
module hog_agg_checker #(
    parameter int COLS    = 80,
    parameter int ROWS    = 60,
    parameter int CELL_PX = 8,
    parameter int NBINS   = 9,
    parameter int PART_W  = 15,
    parameter int SUM_W   = 18,
    parameter int COL_W   = 7,
    parameter int ROW_W   = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   part_valid,
    input logic                   cell_valid,
    input logic [COL_W-1:0]       cell_col,
    input logic [ROW_W-1:0]       cell_row,
    input logic [NBINS*SUM_W-1:0] cell_bins
);

    localparam logic [SUM_W-1:0] BIN_MAX = SUM_W'(CELL_PX * ((2 ** PART_W) - 1));

    // R5: a finished cell always follows an accepted word
    a_r5_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> $past(part_valid));

    // R6: reported position stays inside the cell grid
    a_r6_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> (cell_col < COL_W'(COLS)));

    a_r6_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> (cell_row < ROW_W'(ROWS)));

    // R6: consecutive finished cells are neighbours on the same cell row
    a_r6_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && $past(cell_valid) && $past(rst_n)) |->
            ((cell_col == COL_W'($past(cell_col) + 1'b1)) &&
             (cell_row == $past(cell_row))));

    // R3: no bin exceeds the largest sum of eight full-scale words
    for (genvar b = 0; b < NBINS; b++) begin : g_ovf
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            cell_valid |-> (cell_bins[b*SUM_W +: SUM_W] <= BIN_MAX));
    end

endmodule

bind hog_row_aggregator hog_agg_checker #(
    .COLS    (COLS),
    .ROWS    (ROWS),
    .CELL_PX (CELL_PX),
    .NBINS   (NBINS),
    .PART_W  (PART_W),
    .SUM_W   (SUM_W),
    .COL_W   (COL_W),
    .ROW_W   (ROW_W)
) i_hog_agg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .part_valid (part_valid),
    .cell_valid (cell_valid),
    .cell_col   (cell_col),
    .cell_row   (cell_row),
    .cell_bins  (cell_bins)
);

// File: tb/test_hog_row_aggregator.sv
module test_hog_row_aggregator;

    localparam int IMG_W   = 640;
    localparam int IMG_H   = 480;
    localparam int CELL_PX = 8;
    localparam int NBINS   = 9;
    localparam int MAG_W   = 12;
    localparam int COLS    = IMG_W / CELL_PX;
    localparam int ROWS    = IMG_H / CELL_PX;
    localparam int PART_W  = MAG_W + 3;
    localparam int SUM_W   = PART_W + 3;
    localparam int COL_W   = $clog2(COLS);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int PMAX    = (2 ** PART_W) - 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   sof = 1'b0;
    logic                   part_valid = 1'b0;
    logic [NBINS*PART_W-1:0] part_bins = '0;
    logic                   cell_valid;
    logic [COL_W-1:0]       cell_col;
    logic [ROW_W-1:0]       cell_row;
    logic [NBINS*SUM_W-1:0] cell_bins;

    always #4 clk = ~clk;  // 125 MHz

    hog_row_aggregator #(
        .IMG_W   (IMG_W),
        .IMG_H   (IMG_H),
        .CELL_PX (CELL_PX),
        .NBINS   (NBINS),
        .MAG_W   (MAG_W)
    ) i_hog_row_aggregator (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof),
        .part_valid (part_valid),
        .part_bins  (part_bins),
        .cell_valid (cell_valid),
        .cell_col   (cell_col),
        .cell_row   (cell_row),
        .cell_bins  (cell_bins)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Reference model state
    int unsigned acc [COLS][NBINS];
    int m_col = 0, m_sub = 0, m_row = 0;
    bit exp_v = 0;
    int exp_col = 0, exp_row = 0;
    int unsigned exp_bins [NBINS];
    string bin_tag = "R8";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NBINS*PART_W-1:0] make_part(input int mode);
        logic [NBINS*PART_W-1:0] v;
        for (int b = 0; b < NBINS; b++) begin
            if (mode == 0) v[b*PART_W +: PART_W] = PART_W'(PMAX);
            else           v[b*PART_W +: PART_W] = PART_W'($urandom_range(0, PMAX));
        end
        return v;
    endfunction

    // Compare outputs for the previous clock, then drive the next word
    task automatic step(input bit s, input bit v, input logic [NBINS*PART_W-1:0] p);
        @(negedge clk);
        if (exp_v) begin
            check(cell_valid == 1'b1, "R5", "cell_valid on finished cell", cell_valid, 1);
            check(int'(cell_col) == exp_col, "R6", "cell_col", cell_col, exp_col);
            check(int'(cell_row) == exp_row, "R6", "cell_row", cell_row, exp_row);
            for (int b = 0; b < NBINS; b++)
                check(int'(cell_bins[b*SUM_W +: SUM_W]) == int'(exp_bins[b]), bin_tag,
                      $sformatf("bin %0d", b), cell_bins[b*SUM_W +: SUM_W], exp_bins[b]);
        end else begin
            check(cell_valid == 1'b0, "R5", "cell_valid idle", cell_valid, 0);
        end
        sof        = s;
        part_valid = v;
        part_bins  = p;
        exp_v = 0;
        if (s) begin
            m_col = 0; m_sub = 0; m_row = 0;
        end
        if (v) begin
            for (int b = 0; b < NBINS; b++) begin
                int unsigned pv;
                pv = int'(p[b*PART_W +: PART_W]);
                acc[m_col][b] = (m_sub == 0) ? pv : acc[m_col][b] + pv;
                exp_bins[b] = acc[m_col][b];
            end
            if (m_sub == CELL_PX - 1) begin
                exp_v = 1; exp_col = m_col; exp_row = m_row;
            end
            if (m_col == COLS - 1) begin
                m_col = 0;
                if (m_sub == CELL_PX - 1) begin
                    m_sub = 0;
                    m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
                end else m_sub++;
            end else m_col++;
        end
    endtask

    // Feed n words at the given valid percentage; idle clocks carry junk data
    task automatic feed(input int n, input int pct, input int mode);
        int sent = 0;
        while (sent < n) begin
            if ($urandom_range(1, 100) <= pct) begin
                step(0, 1, make_part(mode));
                sent++;
            end else begin
                step(0, 0, make_part(1));  // R2: ignored word
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        for (int c = 0; c < COLS; c++)
            for (int b = 0; b < NBINS; b++) acc[c][b] = 32'hDEAD;
        repeat (3) @(negedge clk);
        check(cell_valid == 1'b0, "R1", "cell_valid in reset", cell_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cell_valid == 1'b0, "R1", "cell_valid after reset", cell_valid, 0);
        // R1/R3/R2: first cell row at full scale, back to back, no sof
        bin_tag = "R3";
        feed(COLS * CELL_PX, 100, 0);
        // R8/R2: remaining cell rows of the frame with gaps
        bin_tag = "R8";
        feed(COLS * CELL_PX * (ROWS - 1), 80, 1);
        // R6/R4: next frame without sof, row index must wrap to 0
        bin_tag = "R4";
        feed(COLS * CELL_PX, 70, 1);
        // R7: sof alone mid cell row, then a cell row
        feed(COLS * 3 + 17, 90, 1);
        step(1, 0, make_part(1));
        bin_tag = "R7";
        feed(COLS * CELL_PX, 85, 1);
        // R7: sof together with a word, mid cell row
        feed(COLS * 5 + 9, 90, 1);
        step(1, 1, make_part(1));
        feed(COLS * CELL_PX - 1, 85, 1);
        // R3: full-scale cell row after random history
        bin_tag = "R3";
        feed(COLS * CELL_PX, 100, 0);
        step(0, 0, '0);
        step(0, 0, '0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule